// File: doc/BRIEF.md
# Character LCD Row Scan Generator

This block produces the time-multiplexed common (row) scan for a character dot-matrix LCD, running directly from the slow display oscillator clock. It steps through the common lines one at a time. Each common stays selected for a fixed number of clocks, and the number of commons in a frame (the duty) comes from two configuration bits: a two-line flag and a tall-font flag.

For every common period the block gives the one-hot common select, the index of the pattern row that the character fetch logic must read, and a one-clock strobe on the first clock of the period that loads the segment latch. It also gives a polarity signal that flips once per frame, so the panel sees AC drive. A new setting of the configuration bits is applied only when a frame completes, so a frame is never cut short.

Top module: `lcdscan_row_gen`

## Requirements
- R1: With two-line = 0 and tall-font = 0 the scan visits rows 0 to 7 (ROWS_SMALL) in ascending order, then wraps to row 0.
- R2: With two-line = 0 and tall-font = 1 the scan visits rows 0 to 10 (ROWS_TALL) in ascending order, then wraps.
- R3: With two-line = 1 the scan visits rows 0 to 15 (COMS), whatever the tall-font bit is.
- R4: Each row stays selected for LONG_CLKS clocks (default 400) at the 8- and 11-row duties, and for SHORT_CLKS clocks (default 200) at the 16-row duty. A frame therefore lasts 3200, 4400 or 3200 clocks with the defaults.
- R5: `com_sel` has exactly one bit set, and that bit is bit `row_idx`. Bits at or above the active row count stay 0.
- R6: `seg_latch` is 1 on the first clock of every row period, including the first clock after reset, and 0 on every other clock.
- R7: `frame_pol` inverts on the clock where the scan wraps from the last active row to row 0, and at no other time.
- R8: A change of the configuration bits in mid-frame has no effect on the row count or the period length until the current frame has completed.
- R9: After reset `row_idx` = 0, `com_sel` = bit 0 only, `seg_latch` = 1 and `frame_pol` = 0. The first frame always runs at the 8-row duty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Display oscillator clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_two_line | input | 1 | 1 selects the 16-row duty |
| cfg_tall_font | input | 1 | 1 selects 11 rows when cfg_two_line is 0 |
| com_sel | output | COMS | One-hot common select; unused commons held at 0 |
| row_idx | output | $clog2(COMS) | Current pattern row index |
| seg_latch | output | 1 | One-clock strobe at the start of each row period |
| frame_pol | output | 1 | Drive polarity, inverted once per frame |

## Verification
The bench builds the block with LONG_CLKS = 5 and SHORT_CLKS = 3, and keeps the default row counts of 8, 11 and 16. Frames then last 40, 55 and 48 clocks, so many frame wraps, all three duties and repeated mid-frame configuration changes fit into a few hundred clocks. Because the two period lengths differ, a design that applies the wrong period, or applies a new duty before the frame boundary, gives a row timing that visibly differs from the expected one.

// File: rtl/lcdscan_pkg.sv
package lcdscan_pkg;

   typedef enum logic [1:0] {
      DUTY_EIGHTH    = 2'd0,
      DUTY_ELEVENTH  = 2'd1,
      DUTY_SIXTEENTH = 2'd2
   } duty_e;

   // Two-line mode wins over the font bit.
   function automatic duty_e pick_duty(input logic two_line, input logic tall_font);
      if (two_line)
         return DUTY_SIXTEENTH;
      else if (tall_font)
         return DUTY_ELEVENTH;
      else
         return DUTY_EIGHTH;
   endfunction

endpackage

// File: rtl/lcdscan_duty_limits.sv
module lcdscan_duty_limits
   import lcdscan_pkg::*;
#(
   parameter int COMS       = 16,
   parameter int ROWS_SMALL = 8,
   parameter int ROWS_TALL  = 11,
   parameter int LONG_CLKS  = 400,
   parameter int SHORT_CLKS = 200,
   parameter int ROW_W      = 4,
   parameter int TICK_W     = 9
) (
   input  duty_e             duty,
   output logic [ROW_W-1:0]  last_row,
   output logic [TICK_W-1:0] last_tick
);

   localparam logic [ROW_W-1:0]  LAST_SMALL = ROW_W'(ROWS_SMALL - 1);
   localparam logic [ROW_W-1:0]  LAST_TALL  = ROW_W'(ROWS_TALL - 1);
   localparam logic [ROW_W-1:0]  LAST_ALL   = ROW_W'(COMS - 1);
   localparam logic [TICK_W-1:0] END_LONG   = TICK_W'(LONG_CLKS - 1);
   localparam logic [TICK_W-1:0] END_SHORT  = TICK_W'(SHORT_CLKS - 1);

   always_comb begin
      case (duty)
         DUTY_ELEVENTH: begin
            last_row  = LAST_TALL;
            last_tick = END_LONG;
         end
         DUTY_SIXTEENTH: begin
            last_row  = LAST_ALL;
            last_tick = END_SHORT;
         end
         default: begin
            last_row  = LAST_SMALL;
            last_tick = END_LONG;
         end
      endcase
   end

endmodule

// File: rtl/lcdscan_period_timer.sv
module lcdscan_period_timer #(
   parameter int TICK_W = 9
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [TICK_W-1:0] last_tick,
   output logic              period_end,
   output logic              period_start
);

   logic [TICK_W-1:0] tick_q;

   assign period_end   = (tick_q == last_tick);
   assign period_start = (tick_q == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         tick_q <= '0;
      else if (period_end)
         tick_q <= '0;
      else
         tick_q <= tick_q + 1'b1;
   end

endmodule

// File: rtl/lcdscan_row_seq.sv
module lcdscan_row_seq
   import lcdscan_pkg::*;
#(
   parameter int ROW_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             advance,
   input  logic [ROW_W-1:0] last_row,
   input  duty_e            next_duty,
   output logic [ROW_W-1:0] row,
   output logic             pol,
   output duty_e            duty_q
);

   logic wrap;

   assign wrap = advance && (row == last_row);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         row    <= '0;
         pol    <= 1'b0;
         duty_q <= DUTY_EIGHTH;
      end else if (wrap) begin
         row    <= '0;
         pol    <= ~pol;
         duty_q <= next_duty;   // new duty only at frame boundary
      end else if (advance) begin
         row    <= row + 1'b1;
      end
   end

endmodule

// File: rtl/lcdscan_com_drive.sv
module lcdscan_com_drive #(
   parameter int COMS  = 16,
   parameter int ROW_W = 4
) (
   input  logic [ROW_W-1:0] row,
   output logic [COMS-1:0]  com_sel
);

   for (genvar gi = 0; gi < COMS; gi++) begin : g_com
      assign com_sel[gi] = (row == ROW_W'(gi));
   end

endmodule

// File: rtl/lcdscan_row_gen.sv
module lcdscan_row_gen
   import lcdscan_pkg::*;
#(
   parameter int COMS       = 16,
   parameter int ROWS_SMALL = 8,
   parameter int ROWS_TALL  = 11,
   parameter int LONG_CLKS  = 400,
   parameter int SHORT_CLKS = 200,
   localparam int ROW_W     = $clog2(COMS),
   localparam int MAX_CLKS  = (LONG_CLKS > SHORT_CLKS) ? LONG_CLKS : SHORT_CLKS,
   localparam int TICK_W    = $clog2(MAX_CLKS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_two_line,
   input  logic             cfg_tall_font,
   output logic [COMS-1:0]  com_sel,
   output logic [ROW_W-1:0] row_idx,
   output logic             seg_latch,
   output logic             frame_pol
);

   if (COMS < 2 || ROWS_SMALL < 2 || ROWS_TALL < ROWS_SMALL || ROWS_TALL > COMS) begin : g_bad_rows
      $error("lcdscan_row_gen: row counts must satisfy 2 <= small <= tall <= COMS");
   end
   if (LONG_CLKS < 2 || SHORT_CLKS < 2) begin : g_bad_period
      $error("lcdscan_row_gen: period lengths must be at least 2 clocks");
   end

   duty_e             duty_now;
   duty_e             duty_req;
   logic [ROW_W-1:0]  last_row;
   logic [TICK_W-1:0] last_tick;
   logic              period_end;
   logic              period_start;

   assign duty_req = pick_duty(cfg_two_line, cfg_tall_font);

   lcdscan_duty_limits #(
      .COMS       (COMS),
      .ROWS_SMALL (ROWS_SMALL),
      .ROWS_TALL  (ROWS_TALL),
      .LONG_CLKS  (LONG_CLKS),
      .SHORT_CLKS (SHORT_CLKS),
      .ROW_W      (ROW_W),
      .TICK_W     (TICK_W)
   ) limits_i (
      .duty      (duty_now),
      .last_row  (last_row),
      .last_tick (last_tick)
   );

   lcdscan_period_timer #(
      .TICK_W (TICK_W)
   ) timer_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .last_tick    (last_tick),
      .period_end   (period_end),
      .period_start (period_start)
   );

   lcdscan_row_seq #(
      .ROW_W (ROW_W)
   ) seq_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .advance   (period_end),
      .last_row  (last_row),
      .next_duty (duty_req),
      .row       (row_idx),
      .pol       (frame_pol),
      .duty_q    (duty_now)
   );

   lcdscan_com_drive #(
      .COMS  (COMS),
      .ROW_W (ROW_W)
   ) drive_i (
      .row     (row_idx),
      .com_sel (com_sel)
   );

   assign seg_latch = period_start;

endmodule

// File: rtl/lcdscan_row_gen_chk.sv
module lcdscan_row_gen_chk #(
   parameter int COMS       = 16,
   parameter int LONG_CLKS  = 400,
   parameter int SHORT_CLKS = 200,
   parameter int ROW_W      = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic [COMS-1:0]  com_sel,
   input logic [ROW_W-1:0] row_idx,
   input logic             seg_latch,
   input logic             frame_pol
);

   int unsigned gap_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         gap_q <= 0;
      else if (seg_latch)
         gap_q <= 1;
      else if (gap_q != 0)
         gap_q <= gap_q + 1;
   end

   // R5
   com_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(com_sel) == 1 && com_sel[row_idx]);

   // R1
   row_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!$stable(row_idx) && row_idx != '0) |-> row_idx == ROW_W'($past(row_idx) + 1'b1));

   // R6
   latch_on_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(row_idx) |-> seg_latch);

   // R4
   period_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (seg_latch && gap_q != 0) |-> (gap_q == LONG_CLKS || gap_q == SHORT_CLKS));

   // R7
   pol_at_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(frame_pol) |-> (row_idx == '0 && seg_latch && !$stable(row_idx)));

   // R7
   wrap_flips_pol_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (row_idx == '0 && !$stable(row_idx)) |-> !$stable(frame_pol));

endmodule

bind lcdscan_row_gen lcdscan_row_gen_chk #(
   .COMS       (COMS),
   .LONG_CLKS  (LONG_CLKS),
   .SHORT_CLKS (SHORT_CLKS),
   .ROW_W      (ROW_W)
) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .com_sel   (com_sel),
   .row_idx   (row_idx),
   .seg_latch (seg_latch),
   .frame_pol (frame_pol)
);

// File: tb/lcdscan_row_gen_tb_top.sv
module lcdscan_row_gen_tb_top;

   localparam int COMS  = 16;
   localparam int LONG  = 5;
   localparam int SHORT = 3;
   localparam int ROW_W = $clog2(COMS);

   typedef struct {
      int    row;
      bit    latch;
      bit    pol;
      string rtag;
   } item_t;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             cfg_two_line = 1'b0;
   logic             cfg_tall_font = 1'b0;
   logic [COMS-1:0]  com_sel;
   logic [ROW_W-1:0] row_idx;
   logic             seg_latch;
   logic             frame_pol;

   int    n_checks = 0;
   int    n_fails  = 0;
   bit    done     = 1'b0;
   item_t expq[$];

   // model state
   int m_tick = 0;
   int m_row  = 0;
   bit m_pol  = 1'b0;
   int m_rows = 8;
   int m_per  = LONG;
   int cycle  = 0;

   always #2 clk = ~clk;

   lcdscan_row_gen #(
      .COMS       (COMS),
      .LONG_CLKS  (LONG),
      .SHORT_CLKS (SHORT)
   ) dut_i (
      .clk           (clk),
      .rst_n         (rst_n),
      .cfg_two_line  (cfg_two_line),
      .cfg_tall_font (cfg_tall_font),
      .com_sel       (com_sel),
      .row_idx       (row_idx),
      .seg_latch     (seg_latch),
      .frame_pol     (frame_pol)
   );

   function automatic int rows_for(bit n, bit f);
      return n ? 16 : (f ? 11 : 8);
   endfunction

   // push expected values for the current cycle, then advance the model
   task automatic step();
      item_t it;
      string t;
      if (cycle == 0)       t = "R9";
      else if (m_rows == 8)  t = "R1/R4";
      else if (m_rows == 11) t = "R2/R4";
      else                   t = "R3/R4";
      if (rows_for(cfg_two_line, cfg_tall_font) != m_rows) t = {t, "/R8"};
      it.row = m_row; it.latch = (m_tick == 0); it.pol = m_pol; it.rtag = t;
      expq.push_back(it);
      if (m_tick == m_per - 1) begin
         m_tick = 0;
         if (m_row == m_rows - 1) begin
            m_row  = 0;
            m_pol  = ~m_pol;
            m_rows = rows_for(cfg_two_line, cfg_tall_font);
            m_per  = (m_rows == 16) ? SHORT : LONG;
         end else begin
            m_row++;
         end
      end else begin
         m_tick++;
      end
      cycle++;
      @(negedge clk);
   endtask

   task automatic run(input bit n, input bit f, input int clocks);
      cfg_two_line  = n;
      cfg_tall_font = f;
      for (int i = 0; i < clocks; i++) step();
   endtask

   // monitor
   initial begin
      forever begin
         @(negedge clk);
         #1;
         if (expq.size() > 0) begin
            item_t e;
            logic [COMS-1:0] exp_sel;
            e = expq.pop_front();
            exp_sel = COMS'(1) << e.row;
            n_checks++;
            if (int'(row_idx) != e.row) begin
               n_fails++;
               $display("FAIL %s row_idx cycle: got %0d expected %0d", e.rtag, row_idx, e.row);
            end
            n_checks++;
            if (com_sel !== exp_sel) begin
               n_fails++;
               $display("FAIL R5 com_sel: got %h expected %h", com_sel, exp_sel);
            end
            n_checks++;
            if (seg_latch !== e.latch) begin
               n_fails++;
               $display("FAIL R6 seg_latch: got %b expected %b", seg_latch, e.latch);
            end
            n_checks++;
            if (frame_pol !== e.pol) begin
               n_fails++;
               $display("FAIL R7 frame_pol: got %b expected %b", frame_pol, e.pol);
            end
         end
      end
   end

   // driver
   initial begin
      cfg_two_line = 1'b1;            // R9: first frame still at 8 rows
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      run(1'b1, 1'b0, 62);            // R8 pending in first frame, then R3
      run(1'b0, 1'b1, 140);           // R2 after mid-frame change
      run(1'b1, 1'b1, 120);           // R3 with tall font ignored
      run(1'b0, 1'b0, 90);            // R1
      for (int k = 0; k < 30; k++)    // R8: rapid mid-frame toggling
         run(k[0], k[1], 7);
      run(1'b0, 1'b0, 60);
      #1;
      repeat (2) @(negedge clk);
      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
   end

   // watchdog
   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_fails++;
         $display("FAIL R6 watchdog expired: got running expected finished");
         $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
         $finish;
      end
   end

endmodule